// File: doc/BRIEF.md
# Temperature Alarm Status Logic

This block watches a stream of finished temperature conversions and keeps two status flags. The over-temperature flag (OT) tracks samples above a high trip point. The under-temperature flag (UT) tracks samples below a low trip point. Each trip point has a hysteresis point that releases or re-arms its flag. The block also drives one alarm level, which is asserted while either flag is set.

The flags work in one of two modes:

- **Comparator mode.** A flag follows the temperature, with hysteresis applied.
- **Interrupt mode.** A flag latches on an event and is cleared by a status read. The event each flag waits for alternates between crossing its trip point and crossing back over its hysteresis point.

A selectable number of consecutive qualifying conversions is needed before a flag is raised. Shutdown clears both flags. Samples are two's-complement with 0.0625 °C per LSB. The trip and hysteresis points are parameters, in LSB units, with defaults of +100 °C / +90 °C for the high side and −40 °C / −30 °C for the low side.

Top module: `temp_alarm_status`

## Requirements
- R1: When the synchronous active-low reset is applied, `ot_status` and `ut_status` are 0 on the cycle after the reset edge, and `alarm_out` is at its inactive level.
- R2: In comparator mode (`mode_int`=0), OT is set when a valid sample is strictly greater than TH (default 1600). OT stays set until a valid sample is strictly less than TH_HYST (default 1440).
- R3: In comparator mode, UT is set when a valid sample is strictly less than TL (default −640). UT stays set until a valid sample is strictly greater than TL_HYST (default −480).
- R4: A flag is raised only after 2^`fq_sel` consecutive valid samples that meet its current event condition (`fq_sel` 0,1,2,3 → 1,2,4,8). A valid sample that does not meet the condition restarts the count. Each flag changes one cycle after the deciding sample.
- R5: In interrupt mode (`mode_int`=1), a set flag ignores further samples. It stays set until `status_rd` is high, which clears it on the next edge.
- R6: In interrupt mode, each flag's event alternates after each read clear. OT's event moves from "sample above TH" to "sample below TH_HYST" and back. UT's event moves from "sample below TL" to "sample above TL_HYST" and back. After reset, the first event is the trip-point crossing.
- R7: While `shutdown` is 1, both flags are 0 one cycle later and valid samples are ignored. After shutdown ends, interrupt mode restarts at the trip-point event.
- R8: `alarm_out` is high when (OT or UT) is set and `alarm_active_high`=1. It is low when (OT or UT) is set and `alarm_active_high`=0. Otherwise it takes the opposite level.
- R9: If a status read and a valid sample occur in the same cycle in interrupt mode, the read clear (with its event flip) is applied first. The sample is then judged against the flipped event.
- R10: In comparator mode, `status_rd` has no effect on either flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_valid | input | 1 | Marks a completed conversion on `sample_data` |
| sample_data | input | 12 | Signed temperature, 0.0625 °C per LSB |
| mode_int | input | 1 | 0 = comparator mode, 1 = interrupt mode |
| fq_sel | input | 2 | Consecutive-fault depth select: 1, 2, 4 or 8 |
| alarm_active_high | input | 1 | 1 = alarm asserted high, 0 = asserted low |
| shutdown | input | 1 | Clears both flags and ignores samples while high |
| status_rd | input | 1 | Status-register read strobe (clears flags in interrupt mode) |
| ot_status | output | 1 | Over-temperature flag |
| ut_status | output | 1 | Under-temperature flag |
| alarm_out | output | 1 | Alarm level after polarity selection |

## Verification
Each flag hides two pieces of state: a consecutive-event counter and an interrupt-mode event phase. Neither is visible directly.

- A counter that fails to restart or compares against the wrong depth makes a flag rise one or more samples early or late. This shows on the cycle after the sample the requirements name.
- A phase that is wrong stays silent until the following read. Then the flag either re-fires on the wrong crossing or never re-fires.

The stimulus therefore runs each interrupt-mode flag through at least two read-clear cycles. It also places a sample on the same cycle as a read, so a misordered clear shows up immediately.

// File: rtl/temp_alarm_pkg.sv
// Package: shared constants and helpers for the temperature alarm block.
// Assumes samples are two's-complement in 1/16 degree C units.
package temp_alarm_pkg;

    localparam int SAMPLE_W  = 12;
    localparam int FQ_SEL_W  = 2;
    // Counter must hold the largest depth minus one; one spare bit for the compare.
    localparam int FQ_CNT_W  = (1 << FQ_SEL_W) - 1 + 1;

    typedef enum logic {
        PH_TRIP    = 1'b0,   // waiting for the trip-point crossing
        PH_RELEASE = 1'b1    // waiting for the hysteresis crossing
    } ev_phase_t;

    // Decode the depth select into a consecutive-sample requirement.
    function automatic logic [FQ_CNT_W-1:0] fq_depth(input logic [FQ_SEL_W-1:0] sel);
        logic [FQ_CNT_W-1:0] one;
        one = {{(FQ_CNT_W-1){1'b0}}, 1'b1};
        return one << sel;
    endfunction

endpackage

// File: rtl/temp_thresh_cmp.sv
// Module: temp_thresh_cmp
// Judges one sample against a trip point and its hysteresis point.
// HIGH_SIDE=1: trip when above TRIP, release when below HYST.
// HIGH_SIDE=0: trip when below TRIP, release when above HYST.
// Purely combinational; assumes TRIP and HYST are on the correct sides.
module temp_thresh_cmp #(
    parameter int W         = 12,
    parameter int TRIP      = 1600,
    parameter int HYST      = 1440,
    parameter bit HIGH_SIDE = 1'b1
) (
    input  logic [W-1:0] sample,
    output logic         trip,
    output logic         release_ev
);
    localparam logic signed [W-1:0] TRIP_S = TRIP[W-1:0];
    localparam logic signed [W-1:0] HYST_S = HYST[W-1:0];

    logic signed [W-1:0] s;
    assign s = $signed(sample);

    generate
        if (HIGH_SIDE) begin : g_high
            // Over-temperature side comparisons.
            assign trip       = s > TRIP_S;
            assign release_ev = s < HYST_S;
        end else begin : g_low
            // Under-temperature side comparisons.
            assign trip       = s < TRIP_S;
            assign release_ev = s > HYST_S;
        end
    endgenerate
endmodule

// File: rtl/temp_alarm_chan.sv
// Module: temp_alarm_chan
// One status flag with its consecutive-event counter and interrupt-mode phase.
// Assumes trip and release_ev are never both high for the same sample.
// Order inside a cycle: read clear, then sample evaluation, then shutdown override.
module temp_alarm_chan
    import temp_alarm_pkg::*;
#(
    parameter int SEL_W = FQ_SEL_W,
    parameter int CNT_W = FQ_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic             trip,
    input  logic             release_ev,
    input  logic             mode_int,
    input  logic [SEL_W-1:0] fq_sel,
    input  logic             shutdown,
    input  logic             rd,
    output logic             status
);
    logic             st_q, st_d;
    ev_phase_t        ph_q, ph_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] need;
    logic             ev;

    assign need    = fq_depth(fq_sel);
    assign cnt_inc = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};

    // Next-state: read clear, sample qualification, shutdown override.
    always_comb begin
        st_d  = st_q;
        ph_d  = mode_int ? ph_q : PH_TRIP;
        cnt_d = cnt_q;
        ev    = 1'b0;
        if (mode_int && rd && st_q) begin
            st_d  = 1'b0;
            ph_d  = (ph_q == PH_TRIP) ? PH_RELEASE : PH_TRIP;
            cnt_d = '0;
        end
        if (valid) begin
            ev = (mode_int && ph_d == PH_RELEASE) ? release_ev : trip;
            if (mode_int && st_d) begin
                cnt_d = '0;
            end else if (ev) begin
                if (cnt_inc >= need) begin
                    st_d  = 1'b1;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_inc;
                end
            end else begin
                cnt_d = '0;
            end
            if (!mode_int && release_ev) st_d = 1'b0;
        end
        if (shutdown) begin
            st_d  = 1'b0;
            ph_d  = PH_TRIP;
            cnt_d = '0;
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= 1'b0;
            ph_q  <= PH_TRIP;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            ph_q  <= ph_d;
            cnt_q <= cnt_d;
        end
    end

    assign status = st_q;

    // R7: shutdown forces the flag low on the next cycle.
    p_shutdown_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> !status);

    // R5: a latched interrupt flag holds without a read.
    p_intr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_int && status && !rd && !shutdown) |=> status);

    // R5: a read with no sample clears an interrupt flag.
    p_intr_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_int && status && rd && !valid && !shutdown) |=> !status);

    // R10: reads do not disturb a comparator-mode flag.
    p_cmp_read_noeffect_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_int && status && rd && !valid && !shutdown) |=> status);

    // R4: a flag only rises on the cycle after a valid sample.
    p_rise_needs_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status) |-> $past(valid));
endmodule

// File: rtl/temp_alarm_status.sv
// Module: temp_alarm_status (top)
// Builds the OT and UT channels from two threshold comparators and drives
// the polarity-selected alarm level. Thresholds are parameters in LSB units
// (1/16 degree C). Assumes TH > TH_HYST and TL < TL_HYST.
module temp_alarm_status
    import temp_alarm_pkg::*;
#(
    parameter int W       = SAMPLE_W,
    parameter int TH      = 1600,
    parameter int TH_HYST = 1440,
    parameter int TL      = -640,
    parameter int TL_HYST = -480
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_valid,
    input  logic [W-1:0]        sample_data,
    input  logic                mode_int,
    input  logic [FQ_SEL_W-1:0] fq_sel,
    input  logic                alarm_active_high,
    input  logic                shutdown,
    input  logic                status_rd,
    output logic                ot_status,
    output logic                ut_status,
    output logic                alarm_out
);
    logic hi_trip, hi_rel, lo_trip, lo_rel;

    temp_thresh_cmp #(.W(W), .TRIP(TH), .HYST(TH_HYST), .HIGH_SIDE(1'b1)) u_cmp_hi (
        .sample(sample_data), .trip(hi_trip), .release_ev(hi_rel));

    temp_thresh_cmp #(.W(W), .TRIP(TL), .HYST(TL_HYST), .HIGH_SIDE(1'b0)) u_cmp_lo (
        .sample(sample_data), .trip(lo_trip), .release_ev(lo_rel));

    temp_alarm_chan u_ot (
        .clk(clk), .rst_n(rst_n), .valid(sample_valid),
        .trip(hi_trip), .release_ev(hi_rel), .mode_int(mode_int),
        .fq_sel(fq_sel), .shutdown(shutdown), .rd(status_rd),
        .status(ot_status));

    temp_alarm_chan u_ut (
        .clk(clk), .rst_n(rst_n), .valid(sample_valid),
        .trip(lo_trip), .release_ev(lo_rel), .mode_int(mode_int),
        .fq_sel(fq_sel), .shutdown(shutdown), .rd(status_rd),
        .status(ut_status));

    // Alarm level: asserted while either flag is set, polarity applied last.
    assign alarm_out = (ot_status | ut_status) ~^ alarm_active_high;

    // R2: comparator-mode OT cannot be set while the sample is below hysteresis.
    p_cmp_ot_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_int && sample_valid && hi_rel) |=> !ot_status);

    // R3: comparator-mode UT cannot be set while the sample is above hysteresis.
    p_cmp_ut_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_int && sample_valid && lo_rel) |=> !ut_status);
endmodule

// File: tb/sim_temp_alarm_status.sv
// Bench: behavioural reference model compared on every clock.
module sim_temp_alarm_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_valid = 1'b0;
    logic [11:0] sample_data = '0;
    logic        mode_int = 1'b0;
    logic [1:0]  fq_sel = 2'd0;
    logic        alarm_active_high = 1'b0;
    logic        shutdown = 1'b0;
    logic        status_rd = 1'b0;
    logic        ot_status, ut_status, alarm_out;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_req = "R1";
    bit    done    = 1'b0;

    // Reference state per flag: 0 = OT, 1 = UT.
    int m_st[2];
    int m_ph[2];
    int m_cnt[2];

    always #2 clk = ~clk;

    temp_alarm_status u0 (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .sample_data(sample_data), .mode_int(mode_int), .fq_sel(fq_sel),
        .alarm_active_high(alarm_active_high), .shutdown(shutdown),
        .status_rd(status_rd), .ot_status(ot_status), .ut_status(ut_status),
        .alarm_out(alarm_out));

    function automatic bit trip_of(int ch, int t);
        return (ch == 0) ? (t > 1600) : (t < -640);
    endfunction

    function automatic bit rel_of(int ch, int t);
        return (ch == 0) ? (t < 1440) : (t > -480);
    endfunction

    task automatic model_step();
        int t;
        int need;
        bit ev;
        t    = $signed(sample_data);
        need = 1 << fq_sel;
        for (int ch = 0; ch < 2; ch++) begin
            if (!mode_int) m_ph[ch] = 0;
            if (mode_int && status_rd && m_st[ch] == 1) begin
                m_st[ch] = 0; m_ph[ch] = 1 - m_ph[ch]; m_cnt[ch] = 0;
            end
            if (sample_valid) begin
                ev = (mode_int && m_ph[ch] == 1) ? rel_of(ch, t) : trip_of(ch, t);
                if (mode_int && m_st[ch] == 1) m_cnt[ch] = 0;
                else if (ev) begin
                    m_cnt[ch]++;
                    if (m_cnt[ch] >= need) begin m_st[ch] = 1; m_cnt[ch] = 0; end
                end else m_cnt[ch] = 0;
                if (!mode_int && rel_of(ch, t)) m_st[ch] = 0;
            end
            if (shutdown) begin m_st[ch] = 0; m_ph[ch] = 0; m_cnt[ch] = 0; end
        end
    endtask

    task automatic check(string what, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // Advance the model on each edge, then compare just after it.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int ch = 0; ch < 2; ch++) begin m_st[ch] = 0; m_ph[ch] = 0; m_cnt[ch] = 0; end
        end else model_step();
        #1;
        if (!done) begin
            check("ot_status", ot_status, m_st[0][0]);
            check("ut_status", ut_status, m_st[1][0]);
            check("alarm_out", alarm_out,
                  alarm_active_high ? (m_st[0][0] | m_st[1][0]) : ~(m_st[0][0] | m_st[1][0]));
        end
    end

    task automatic smp(int t);
        @(negedge clk); sample_valid = 1'b1; sample_data = t[11:0];
        @(negedge clk); sample_valid = 1'b0;
    endtask

    task automatic rd_pulse();
        @(negedge clk); status_rd = 1'b1;
        @(negedge clk); status_rd = 1'b0;
    endtask

    task automatic rd_smp(int t);
        @(negedge clk); status_rd = 1'b1; sample_valid = 1'b1; sample_data = t[11:0];
        @(negedge clk); status_rd = 1'b0; sample_valid = 1'b0;
    endtask

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        cur_req = "R2";
        smp(1500); smp(1601); smp(1500); smp(1439); smp(1700); smp(1440);
        cur_req = "R10";
        rd_pulse(); rd_pulse();
        smp(1400);

        cur_req = "R3";
        smp(-600); smp(-641); smp(-500); smp(-479); smp(-900); smp(-480);
        cur_req = "R10";
        rd_pulse();
        smp(0);

        cur_req = "R4";
        fq_sel = 2'd2;
        smp(1601); smp(1601); smp(1601); smp(1000);
        smp(1601); smp(1601); smp(1601); smp(1601); smp(1000);
        fq_sel = 2'd3;
        for (int i = 0; i < 7; i++) smp(-700);
        smp(-620);
        for (int i = 0; i < 8; i++) smp(-700);
        smp(0);
        fq_sel = 2'd1;
        smp(1700); @(negedge clk); smp(1700); smp(0);

        cur_req = "R8";
        smp(1700);
        alarm_active_high = 1'b1; repeat (2) @(negedge clk);
        smp(0);
        alarm_active_high = 1'b0; repeat (2) @(negedge clk);
        alarm_active_high = 1'b1;

        cur_req = "R5";
        fq_sel = 2'd0; mode_int = 1'b1;
        smp(1601); smp(1000); smp(1700); repeat (3) @(negedge clk);
        rd_pulse();

        cur_req = "R6";
        smp(1500); smp(1400); smp(1700); rd_pulse();
        smp(1400); smp(1601); rd_pulse();
        smp(-641); smp(-700); rd_pulse();
        smp(-700); smp(-479); rd_pulse();
        smp(-600);

        cur_req = "R9";
        smp(1601); rd_smp(1400); rd_smp(1601); smp(1650); rd_pulse();

        cur_req = "R7";
        smp(1601);
        @(negedge clk); shutdown = 1'b1;
        smp(1700); smp(-700);
        @(negedge clk); shutdown = 1'b0;
        smp(1400); smp(1700); rd_pulse();
        mode_int = 1'b0;
        smp(-700);
        @(negedge clk); shutdown = 1'b1;
        repeat (2) @(negedge clk); shutdown = 1'b0;
        smp(0);

        cur_req = "R1";
        smp(1700);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog %s: actual timeout expected completion", cur_req);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule